// File: doc/BRIEF.md
# Indirect FIFO with Bulk Value Substitution

The block is a fixed-depth first-in first-out queue of data words with one extra operation: every queued word equal to a compare value can be turned into a change value, and this takes the same single cycle whatever the queue depth. The words are not held in the queue. The queue holds small slot numbers, and each slot number points into a value table that is searched by content. When several queued entries carry the same word, they share one slot. Rewriting that one slot therefore rewrites every queued copy at once.

After an initial fill the queue stays full. Each step pushes one word. Once the queue is full, the same step also pops the oldest word, which appears on the output one cycle later. A substitution can only be requested together with a step.

Within one step the work is ordered as follows. The oldest entry is popped first. The substitution is then applied to the entries that remain. Last, the incoming word is looked up in the table: it reuses a live slot holding the same value, or else takes the lowest-numbered free slot. Each slot keeps a reference count, and a slot becomes free again when its count falls to zero. The table has more slots than the queue has entries, so allocation cannot fail.

Top module: `ref_subst_fifo`

## Requirements
- R1: After reset the queue is empty: `full_o` is low and `pop_valid_o` is low.
- R2: The first DEPTH steps only fill the queue, and no word leaves during them. `full_o` goes high right after the DEPTH-th step and then stays high.
- R3: When a step occurs while `full_o` is high, the oldest queued word is removed. It appears on `pop_data_o`, with `pop_valid_o` high, in the cycle after that step. Words leave in the order they were pushed.
- R4: `repl_en_i` has no effect unless `step_i` is high in the same cycle. A cycle with `step_i` low changes no queued word and raises no `pop_valid_o`.
- R5: A step with `repl_en_i` high turns every queued word equal to `repl_from_i` into `repl_to_i`, in that one step, whatever the number of copies.
- R6: The word popped by a step that also performs a substitution is delivered with its value from before the substitution.
- R7: The word pushed by a step is not affected by the substitution requested in that same step.
- R8: If the change value is already queued, the two groups of entries merge. A later substitution of that value changes the entries from both groups.
- R9: A substitution whose compare value is not queued leaves every queued word unchanged.
- R10: Equal words share storage and freed slots are reused. A long stream of distinct words returns every word intact.
- R11: Each step that occurs while the queue is full performs a push and a pop together, so the queue occupancy stays at DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Push a word (and pop the oldest word once full) |
| push_data_i | input | DATA_W | Word to enqueue |
| repl_en_i | input | 1 | Request a substitution with this step |
| repl_from_i | input | DATA_W | Compare value |
| repl_to_i | input | DATA_W | Change value |
| full_o | output | 1 | Queue has reached DEPTH entries |
| pop_valid_o | output | 1 | `pop_data_o` holds a word popped by the previous step |
| pop_data_o | output | DATA_W | Popped word |

## Verification
A wrong reference count or a slot freed too early does not show at once. The damage appears only when the affected entry reaches the head of the queue, up to DEPTH steps later. At that point it shows as a wrong popped word, either because a fresh allocation overwrote the shared slot or because a substitution leaked into an unrelated entry. For this reason each scenario drains the whole queue after its stimulus and compares every popped word with a value-level model. The substitution scenarios place copies at the head, in the middle and at the tail, so that the ordering rules within a step can be checked.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
   function automatic int safe_clog2(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/rsf_lowest_sel.sv
module rsf_lowest_sel #(
   parameter int N = 4,
   parameter int W = 2
) (
   input  logic [N-1:0] req_i,
   output logic         found_o,
   output logic [W-1:0] idx_o
);
   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            found_o = 1'b1;
            idx_o   = W'(i);
         end
      end
   end
endmodule

// File: rtl/rsf_slot_table.sv
module rsf_slot_table #(
   parameter int DATA_W = 8,
   parameter int SLOTS  = 9,
   parameter int IDX_W  = 4,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   input  logic              pop_i,
   input  logic [IDX_W-1:0]  pop_idx_i,
   input  logic              repl_i,
   input  logic [DATA_W-1:0] repl_from_i,
   input  logic [DATA_W-1:0] repl_to_i,
   input  logic [DATA_W-1:0] push_data_i,
   output logic [IDX_W-1:0]  push_idx_o,
   output logic [DATA_W-1:0] pop_val_o
);
   logic [SLOTS-1:0]  live_v, hit_v, free_v;
   logic [DATA_W-1:0] val_cur [SLOTS];
   logic [CNT_W-1:0]  cnt_cur [SLOTS];
   logic              hit_found, free_found;
   logic [IDX_W-1:0]  hit_idx, free_idx;

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic [DATA_W-1:0] val_q, val_ar;
      logic [CNT_W-1:0]  cnt_q, cnt_ap;
      logic              rmatch;

      assign cnt_ap    = cnt_q - CNT_W'(pop_i && (pop_idx_i == IDX_W'(s)));
      assign live_v[s] = (cnt_ap != '0);
      assign rmatch    = repl_i && live_v[s] && (val_q == repl_from_i);
      assign val_ar    = rmatch ? repl_to_i : val_q;
      assign hit_v[s]  = live_v[s] && (val_ar == push_data_i);
      assign free_v[s] = !live_v[s];
      assign val_cur[s] = val_q;
      assign cnt_cur[s] = cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            val_q <= '0;
            cnt_q <= '0;
         end else if (step_i) begin
            if (!hit_found && (free_idx == IDX_W'(s)))
               val_q <= push_data_i;
            else
               val_q <= val_ar;
            cnt_q <= cnt_ap + CNT_W'(push_idx_o == IDX_W'(s));
         end
      end
   end

   rsf_lowest_sel #(.N(SLOTS), .W(IDX_W)) u_hit_sel (
      .req_i(hit_v), .found_o(hit_found), .idx_o(hit_idx));
   rsf_lowest_sel #(.N(SLOTS), .W(IDX_W)) u_free_sel (
      .req_i(free_v), .found_o(free_found), .idx_o(free_idx));

   assign push_idx_o = hit_found ? hit_idx : free_idx;
   assign pop_val_o  = val_cur[pop_idx_i];

   // R10
   alloc_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |-> (hit_found || free_found));

   // R3
   head_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> (cnt_cur[pop_idx_i] != '0));
endmodule

// File: rtl/rsf_idx_queue.sv
module rsf_idx_queue #(
   parameter int DEPTH = 8,
   parameter int IDX_W = 4,
   parameter int PTR_W = 3,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  logic [IDX_W-1:0] push_idx_i,
   output logic             full_o,
   output logic [IDX_W-1:0] head_idx_o
);
   logic [IDX_W-1:0] ring [DEPTH];
   logic [PTR_W-1:0] head_q, tail_q;
   logic [CNT_W-1:0] fill_q;

   function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign full_o     = (fill_q == CNT_W'(DEPTH));
   assign head_idx_o = ring[head_q];

   always_ff @(posedge clk) begin
      if (step_i) ring[tail_q] <= push_idx_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         fill_q <= '0;
      end else if (step_i) begin
         tail_q <= nxt(tail_q);
         if (full_o) head_q <= nxt(head_q);
         else        fill_q <= fill_q + 1'b1;
      end
   end

   // R2
   stay_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full_o |=> full_o);

   // R11
   ptr_meet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full_o |-> (head_q == tail_q));
endmodule

// File: rtl/ref_subst_fifo.sv
module ref_subst_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8,
   parameter int SLOTS  = DEPTH + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   input  logic [DATA_W-1:0] push_data_i,
   input  logic              repl_en_i,
   input  logic [DATA_W-1:0] repl_from_i,
   input  logic [DATA_W-1:0] repl_to_i,
   output logic              full_o,
   output logic              pop_valid_o,
   output logic [DATA_W-1:0] pop_data_o
);
   import rsf_pkg::*;

   localparam int IDX_W = safe_clog2(SLOTS);
   localparam int PTR_W = safe_clog2(DEPTH);
   localparam int CNT_W = safe_clog2(DEPTH + 1);

   initial begin : param_chk
      assert (SLOTS > DEPTH) else $error("SLOTS must exceed DEPTH");
      assert (DEPTH >= 2)    else $error("DEPTH must be at least 2");
      assert (DATA_W >= 1)   else $error("DATA_W must be positive");
   end

   logic             pop_fire, repl_fire;
   logic [IDX_W-1:0] head_idx, push_idx;
   logic [DATA_W-1:0] head_val;

   assign pop_fire  = step_i && full_o;
   assign repl_fire = step_i && repl_en_i;

   rsf_idx_queue #(.DEPTH(DEPTH), .IDX_W(IDX_W), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_queue (
      .clk(clk), .rst_n(rst_n), .step_i(step_i), .push_idx_i(push_idx),
      .full_o(full_o), .head_idx_o(head_idx));

   rsf_slot_table #(.DATA_W(DATA_W), .SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_table (
      .clk(clk), .rst_n(rst_n), .step_i(step_i), .pop_i(pop_fire),
      .pop_idx_i(head_idx), .repl_i(repl_fire), .repl_from_i(repl_from_i),
      .repl_to_i(repl_to_i), .push_data_i(push_data_i),
      .push_idx_o(push_idx), .pop_val_o(head_val));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pop_valid_o <= 1'b0;
         pop_data_o  <= '0;
      end else begin
         pop_valid_o <= pop_fire;
         if (pop_fire) pop_data_o <= head_val;
      end
   end

   // R3
   pop_after_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_valid_o |-> $past(full_o));

   // R4
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step_i |=> !pop_valid_o);
endmodule

// File: tb/ref_subst_fifo_bench.sv
module ref_subst_fifo_bench;
   localparam int DW = 8;
   localparam int D  = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic step_i = 1'b0, repl_en_i = 1'b0;
   logic [DW-1:0] push_data_i = '0, repl_from_i = '0, repl_to_i = '0;
   logic full_o, pop_valid_o;
   logic [DW-1:0] pop_data_o;

   int checks = 0, errors = 0;
   logic [DW-1:0] mq [D];
   int mfill = 0;

   always #2.5 clk = ~clk;

   ref_subst_fifo #(.DATA_W(DW), .DEPTH(D)) u_ref_subst_fifo (
      .clk(clk), .rst_n(rst_n), .step_i(step_i), .push_data_i(push_data_i),
      .repl_en_i(repl_en_i), .repl_from_i(repl_from_i), .repl_to_i(repl_to_i),
      .full_o(full_o), .pop_valid_o(pop_valid_o), .pop_data_o(pop_data_o));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_step(input logic [DW-1:0] v, input logic ren,
                          input logic [DW-1:0] from, input logic [DW-1:0] to,
                          input string req);
      logic ev;
      logic [DW-1:0] ed;
      ev = (mfill == D);
      ed = mq[0];
      if (ev) begin
         for (int i = 0; i < D - 1; i++) mq[i] = mq[i+1];
         mfill--;
      end
      if (ren) for (int i = 0; i < mfill; i++) if (mq[i] == from) mq[i] = to;
      mq[mfill] = v;
      mfill++;
      step_i = 1'b1; push_data_i = v; repl_en_i = ren;
      repl_from_i = from; repl_to_i = to;
      @(posedge clk); #1;
      step_i = 1'b0; repl_en_i = 1'b0;
      chk({req, " valid"}, int'(pop_valid_o), int'(ev));
      if (ev) chk({req, " data"}, int'(pop_data_o), int'(ed));
      chk({req, " full"}, int'(full_o), int'(mfill == D));
   endtask

   task automatic drain(input string req);
      for (int i = 0; i < D; i++) do_step(8'hF0 + 8'(i), 1'b0, '0, '0, req);
   endtask

   task automatic t_reset;
      chk("R1 full", int'(full_o), 0);
      chk("R1 valid", int'(pop_valid_o), 0);
   endtask

   task automatic t_fill;
      for (int i = 0; i < D; i++) do_step(8'(i % 3), 1'b0, '0, '0, "R2 fill");
      chk("R2 full after fill", int'(full_o), 1);
   endtask

   task automatic t_stream;
      for (int i = 0; i < 12; i++) do_step(8'(i * 5 % 4 + 16), 1'b0, '0, '0, "R3 order R11");
   endtask

   task automatic t_idle;
      repl_en_i = 1'b1; repl_from_i = mq[2]; repl_to_i = 8'hEE;
      @(posedge clk); #1;
      repl_en_i = 1'b0;
      chk("R4 idle no pop", int'(pop_valid_o), 0);
      chk("R4 idle full", int'(full_o), 1);
      drain("R4 untouched");
   endtask

   task automatic t_replace;
      do_step(8'h33, 1'b0, '0, '0, "R5 setup");
      for (int i = 0; i < 3; i++) do_step(8'h21 + 8'(i), 1'b0, '0, '0, "R5 setup");
      do_step(8'h33, 1'b0, '0, '0, "R5 setup");
      do_step(8'h27, 1'b0, '0, '0, "R5 setup");
      do_step(8'h33, 1'b0, '0, '0, "R5 setup");
      do_step(8'h28, 1'b0, '0, '0, "R5 setup");
      // head is 33: R6 pre-substitution pop, R7 pushed 33 stays 33
      do_step(8'h33, 1'b1, 8'h33, 8'h44, "R6 R7 R5 replace");
      drain("R5 R7 drain");
   endtask

   task automatic t_merge;
      do_step(8'h44, 1'b0, '0, '0, "R8 setup");
      do_step(8'h55, 1'b0, '0, '0, "R8 setup");
      do_step(8'h44, 1'b0, '0, '0, "R8 setup");
      do_step(8'h55, 1'b0, '0, '0, "R8 setup");
      do_step(8'h01, 1'b1, 8'h44, 8'h55, "R8 merge");
      do_step(8'h02, 1'b1, 8'h55, 8'h66, "R8 merged replace");
      do_step(8'h03, 1'b1, 8'h99, 8'h77, "R9 no match");
      drain("R8 R9 drain");
   endtask

   task automatic t_churn;
      for (int i = 0; i < 48; i++) do_step(8'(i * 7 + 1), (i % 5) == 0, 8'(i * 7 - 13), 8'hA5, "R10 churn");
      drain("R10 drain");
   endtask

   initial begin : watchdog
      #200000;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #12 rst_n = 1'b1;
      @(posedge clk); #1;
      t_reset();
      t_fill();
      t_stream();
      t_idle();
      t_replace();
      t_merge();
      t_churn();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule